// File: doc/BRIEF.md
# Frame Alignment Measurement Unit

This unit measures how far an external evaluation signal lags the reference frame pulse. The result is given in half master-clock periods. Software controls it through a start bit. The start bit must first stay low across a whole frame, which arms the unit. A low-to-high change of the start bit then launches a measurement.

The measurement window opens at the next reference frame edge and runs for exactly one frame. At the frame edge that closes the window, the unit latches a 12-bit result and raises a complete flag. The flag stays high until software drops the start bit.

A mode input chooses the edge pair that is compared. Mode 0 times a falling edge of the evaluation input against a falling edge of the frame pulse. Mode 1 does the same with rising edges. While the wide-frame-pulse disable input is high, no measurement runs and the flag stays low.

Top module: `frame_align_meter`

## Requirements
- R1: A rising start bit launches a measurement only if the start bit was low at two consecutive reference frame edges. A rising start bit without that history is ignored.
- R2: A measurement starts only on a low-to-high change of `startBit`. The measurement window opens at the first reference frame edge after that change.
- R3: `complete` stays low while the window is open. It rises two clock cycles after the second reference frame edge that follows the start change, and the port timing of that edge is as for R4.
- R4: `result` is the distance in half clock periods from the reference edge to the first qualifying evaluation edge in the window, counting from 0 to 2F-1 for a frame of F cycles. A `framePulse` change made just after a falling clock edge is taken as reference time 0. An `evalIn` change made d half periods after that gives a result of d.
- R5: While `startBit` stays high after completion, `complete` stays high and `result` does not change, whatever the evaluation input does.
- R6: When `startBit` goes low, `complete` clears within two clock cycles. `result` keeps its last value.
- R7: With `edgeMode` = 0 only falling edges of both inputs count. With `edgeMode` = 1 only rising edges count. An evaluation edge of the other polarity never sets the result.
- R8: If no qualifying evaluation edge arrives in the window, `result` is 0xFFF. Distances above 4094 half periods also read as 0xFFF.
- R9: While `wideMode` is high, no measurement runs and `complete` is low from the next cycle on. A measurement in progress is abandoned.
- R10: After reset, `complete` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | Reference frame pulse |
| evalIn | input | 1 | Evaluation signal whose delay is measured |
| startBit | input | 1 | Software start bit |
| edgeMode | input | 1 | 0: falling edges, 1: rising edges |
| wideMode | input | 1 | Disables measurement when high |
| complete | output | 1 | Measurement complete flag |
| result | output | 12 | Measured offset in half clock periods |

## Verification
The assertions assume that `edgeMode` is changed only while no measurement runs. They also assume that the frame pulse makes exactly one qualifying edge per frame, so that frame edges are unambiguous. The stimulus respects both. It switches mode only between complete measurement sequences, and it drives one short frame pulse per frame. The evaluation pulse returns to idle well inside the frame, so one frame's pulse never spills into the next frame's window.

// File: rtl/fam_pkg.sv
package fam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MEAS,
    ST_DONE
  } famState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCap;  // forget any earlier capture
    logic openWin;   // this cycle holds the opening reference edge
    logic inWin;     // window open, not the opening cycle
    logic publish;   // copy the capture to the result register
  } famCtl_t;
endpackage

// File: rtl/fam_datapath.sv
module fam_datapath
  import fam_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             evalIn,
  input  logic             edgeMode,
  input  famCtl_t          ctl,
  output logic             refEdge,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] SAT_VAL = {RES_W{1'b1}};
  localparam logic [RES_W:0]   STEP    = (RES_W+1)'(2);

  logic fpQ, fpPrevQ;
  logic evalPosQ, evalMidQ, midOldQ;
  logic [RES_W-1:0] cntQ, capQ, resultQ;
  logic foundQ;

  // mid-cycle sample of the evaluation input gives half-period resolution
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) evalMidQ <= 1'b0;
    else       evalMidQ <= evalIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpQ      <= 1'b0;
      fpPrevQ  <= 1'b0;
      evalPosQ <= 1'b0;
      midOldQ  <= 1'b0;
    end else begin
      fpQ      <= framePulse;
      fpPrevQ  <= fpQ;
      evalPosQ <= evalIn;
      midOldQ  <= evalMidQ;
    end
  end

  assign refEdge = edgeMode ? (fpQ & ~fpPrevQ) : (~fpQ & fpPrevQ);

  // earlyEdge: between the last mid sample and this posedge sample
  // lateEdge: between this posedge sample and the following mid sample
  logic earlyEdge, lateEdge;
  assign earlyEdge = edgeMode ? (~midOldQ & evalPosQ) : (midOldQ & ~evalPosQ);
  assign lateEdge  = edgeMode ? (~evalPosQ & evalMidQ) : (evalPosQ & ~evalMidQ);

  logic [RES_W-1:0] base, lateVal, nextCnt;
  logic [RES_W:0]   sumOne, sumTwo;
  logic             capEn;

  assign base    = ctl.openWin ? '0 : cntQ;
  assign sumOne  = {1'b0, base} + (RES_W+1)'(1);
  assign lateVal = sumOne[RES_W] ? SAT_VAL : sumOne[RES_W-1:0];
  assign sumTwo  = {1'b0, base} + STEP;
  assign nextCnt = sumTwo[RES_W] ? SAT_VAL : sumTwo[RES_W-1:0];
  assign capEn   = (ctl.openWin | ctl.inWin) & ~foundQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      capQ    <= SAT_VAL;
      foundQ  <= 1'b0;
      resultQ <= '0;
    end else begin
      if (ctl.openWin | ctl.inWin) cntQ <= nextCnt;
      if (ctl.clearCap) begin
        capQ   <= SAT_VAL;
        foundQ <= 1'b0;
      end else if (capEn && earlyEdge) begin
        capQ   <= base;
        foundQ <= 1'b1;
      end else if (capEn && lateEdge) begin
        capQ   <= lateVal;
        foundQ <= 1'b1;
      end
      if (ctl.publish) resultQ <= foundQ ? capQ : SAT_VAL;
    end
  end

  assign result = resultQ;

  // R4
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inWin |=> cntQ >= $past(cntQ));

  // R4
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (foundQ && !ctl.clearCap) |=> $stable(capQ));
endmodule

// File: rtl/fam_control.sv
module fam_control
  import fam_pkg::*;
#(
  parameter int ARM_EDGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startBit,
  input  logic    wideMode,
  input  logic    refEdge,
  output famCtl_t ctl,
  output logic    complete
);
  localparam int ARM_W = $clog2(ARM_EDGES + 1);
  localparam logic [ARM_W-1:0] ARM_MAX = ARM_W'(ARM_EDGES);

  famState_t stateQ, stateD;
  logic sfeQ, sfePrevQ;
  logic [ARM_W-1:0] lowCntQ;
  logic armed, startRise;

  assign armed     = (lowCntQ == ARM_MAX);
  assign startRise = sfeQ & ~sfePrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sfeQ     <= 1'b0;
      sfePrevQ <= 1'b0;
      lowCntQ  <= '0;
    end else begin
      sfeQ     <= startBit;
      sfePrevQ <= sfeQ;
      if (sfeQ)                          lowCntQ <= '0;
      else if (refEdge && !armed)        lowCntQ <= lowCntQ + ARM_W'(1);
    end
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    if (wideMode || !sfeQ) begin
      stateD = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (startRise && armed) begin
          stateD       = ST_WAIT;
          ctl.clearCap = 1'b1;
        end
        ST_WAIT: if (refEdge) begin
          stateD      = ST_MEAS;
          ctl.openWin = 1'b1;
        end
        ST_MEAS: if (refEdge) begin
          stateD      = ST_DONE;
          ctl.publish = 1'b1;
        end else begin
          ctl.inWin = 1'b1;
        end
        ST_DONE: stateD = ST_DONE;
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign complete = (stateQ == ST_DONE);

  // R3
  done_on_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(complete) |-> $past(refEdge));

  // R9
  wide_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    wideMode |=> !complete);

  // R6
  start_low_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |=> ##1 !complete);
endmodule

// File: rtl/frame_align_meter.sv
module frame_align_meter
  import fam_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int ARM_EDGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             evalIn,
  input  logic             startBit,
  input  logic             edgeMode,
  input  logic             wideMode,
  output logic             complete,
  output logic [RES_W-1:0] result
);
  famCtl_t ctl;
  logic    refEdge;

  fam_control #(.ARM_EDGES(ARM_EDGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startBit (startBit),
    .wideMode (wideMode),
    .refEdge  (refEdge),
    .ctl      (ctl),
    .complete (complete)
  );

  fam_datapath #(.RES_W(RES_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .evalIn     (evalIn),
    .edgeMode   (edgeMode),
    .ctl        (ctl),
    .refEdge    (refEdge),
    .result     (result)
  );

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (complete && $past(complete)) |-> $stable(result));
endmodule

// File: tb/sim_frame_align_meter.sv
module sim_frame_align_meter;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic framePulse = 1'b1, evalIn = 1'b1, startBit = 1'b0;
  logic edgeMode = 1'b0, wideMode = 1'b0;
  logic complete;
  logic [11:0] result;

  int testCount = 0, failCount = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  frame_align_meter u0 (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .evalIn(evalIn),
    .startBit(startBit), .edgeMode(edgeMode), .wideMode(wideMode),
    .complete(complete), .result(result)
  );

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one frame of fr cycles, stepped in half periods; h=0 is the reference change
  task automatic runFrame(input int fr, input int d, input int sfeSet);
    for (int h = 0; h < 2 * fr; h++) begin
      if (h % 2 == 0) begin @(negedge clk); #2; end
      else #(HALF);
      if (h == 0) framePulse = edgeMode;
      if (h == 2) framePulse = ~edgeMode;
      if (d >= 0 && h == d)     evalIn = edgeMode;
      if (d >= 0 && h == d + 4) evalIn = ~edgeMode;
      if (h == fr && sfeSet >= 0) startBit = sfeSet[0];
    end
  endtask

  task automatic measure(input int fr, input int d, input int expRes);
    runFrame(fr, d, 0);
    runFrame(fr, d, -1);
    runFrame(fr, d, -1);
    runFrame(fr, d, 1);
    runFrame(fr, d, -1);
    check("R3 complete low in window", complete, 0);
    runFrame(fr, d, -1);
    check("R2 R3 complete after two frames", complete, 1);
    check("R4 R7 R8 result", result, expRes);
    runFrame(fr, -1, -1);
    check("R5 complete held", complete, 1);
    check("R5 result held", result, expRes);
    runFrame(fr, d, 0);
    check("R6 complete cleared", complete, 0);
    check("R6 result kept", result, expRes);
  endtask

  task automatic setMode(input logic m);
    edgeMode   = m;
    framePulse = ~m;
    evalIn     = ~m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check("R10 complete at reset", complete, 0);
    check("R10 result at reset", result, 0);

    // R7 mode 0 (falling) and mode 1 (rising) sweeps, R4 offsets 0..11
    for (int m = 0; m < 2; m++) begin
      setMode(m[0]);
      for (int d = 0; d < 12; d++) measure(8, d, d);
    end

    // R8 no qualifying edge in the window
    setMode(1'b0);
    measure(8, -1, 12'hFFF);
    // R4 long offset, R8 saturation
    measure(2100, 4000, 4000);
    measure(2100, 4150, 12'hFFF);

    // R1 start bit low across only one reference edge: rise ignored
    measure(8, 5, 5);
    runFrame(8, 3, 1);
    runFrame(8, 3, -1);
    runFrame(8, 3, -1);
    runFrame(8, 3, -1);
    check("R1 unarmed start ignored", complete, 0);
    check("R1 result untouched", result, 5);
    runFrame(8, 3, 0);

    // R9 wide-frame-pulse mode blocks measurement
    wideMode = 1'b1;
    runFrame(8, 6, 0);
    runFrame(8, 6, -1);
    runFrame(8, 6, -1);
    runFrame(8, 6, 1);
    runFrame(8, 6, -1);
    runFrame(8, 6, -1);
    check("R9 complete stays low", complete, 0);
    check("R9 result untouched", result, 5);
    runFrame(8, 6, 0);
    wideMode = 1'b0;

    // R9 abort in progress, then R1 re-arm and measure normally
    runFrame(8, 6, -1);
    runFrame(8, 6, -1);
    runFrame(8, 6, 1);
    runFrame(8, 6, -1);
    wideMode = 1'b1;
    runFrame(8, 6, -1);
    check("R9 abort keeps complete low", complete, 0);
    wideMode = 1'b0;
    measure(8, 9, 9);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule